// File: doc/BRIEF.md
# Compare-Match Event Timer

This block is an up-counting event timer driven by a slow tick. Software controls it through four word-wide registers that sit inside one decoded address page. While the timer is running, the counter advances by one on every tick and is compared with a programmed match value. The first time the two are equal, a level interrupt is raised. A downstream controller detects that interrupt on its rising edge.

Two further controls shape the count. A clear register is level-held: while it holds 1, the count is forced to zero. Software therefore pulses it by writing 1 and then 0. A second control bit chooses between two behaviours at a match: the counter either wraps to zero or keeps counting past the match value.

To arm an event, software stops the timer, clears the count, writes a relative match value (between 0xF and 0x7FFFFFFF), and then sets only the run bit. The interrupt handler stops the timer again by writing 0 to the control register. The tick is a one-cycle enable pulse in the bus clock domain.

Top module: `cmt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The register map uses byte offsets, with `bus_addr[1:0]` ignored. The match register is at 0x0 and holds any 32-bit value, including 0x7FFFFFFF and 0xF. An address with any bit set above bit 3 reads zero, and a write to it changes no register.
- R3: The control register is at 0x8. Bit 0 is run and bit 1 is wrap-on-match. Reads return these two bits, and every upper bit reads zero.
- R4: The count register at 0x4 rises by exactly one on each clock edge where `tick` is 1 and run is 1. The count holds when run is 0 or `tick` is 0.
- R5: Writes to the count register are ignored.
- R6: Writing 1 to bit 0 of the clear register (0xC) zeroes the count at that write's clock edge. The count stays zero, even while ticks arrive, for as long as the bit reads 1. Counting resumes after 0 is written.
- R7: With wrap-on-match set, a tick that arrives while count equals match sets the count to 0. With the bit clear, the count moves on to match+1.
- R8: With run set, `irq` goes high at the clock edge after the one that made count equal match. It stays high while the count moves on or wraps.
- R9: `irq` drops at the clock edge of a write to the control register with bit 0 equal to 0. It also drops at the clock edge of any write to the match register.
- R10: While run is 0, `irq` stays low even if count equals match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse of the slow count clock |
| bus_addr | input | ADDR_W | Byte address within the page |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq | output | 1 | Registered match interrupt level |

## Verification
The embedded properties assume the following about the inputs:
- `tick` and `bus_wr` are sampled as one-cycle, clock-synchronous levels.
- Reset is held for at least one edge before anything is checked.

The bench changes every input only on the falling clock edge, so each rising edge sees one settled combination. It then sweeps several match values, with and without wrap, while holding `tick` high. The expected count and interrupt for each edge are derived arithmetically, as the tick index modulo match+1 and the tick index compared with match.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Register selector decoded from address bits [3:2]; order fixed by the map.
    typedef enum logic [1:0] {
        SEL_MATCH = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    localparam int unsigned SEL_LSB   = 2;
    localparam int unsigned SEL_MSB   = 3;
    localparam int unsigned CTRL_BITS = 2;

    typedef struct packed {
        logic wrap_en;  // bit 1
        logic run;      // bit 0
    } ctrl_t;

    typedef struct packed {
        logic match;
        logic ctrl;
        logic clear;
    } wr_strobe_t;

    function automatic ctrl_t ctrl_from_bits(input logic [CTRL_BITS-1:0] b);
        ctrl_t c;
        c.run     = b[0];
        c.wrap_en = b[1];
        return c;
    endfunction

    function automatic wr_strobe_t decode_write(input logic wr, input logic mapped,
                                                input reg_sel_e sel);
        wr_strobe_t s;
        s.match = wr && mapped && (sel == SEL_MATCH);
        s.ctrl  = wr && mapped && (sel == SEL_CTRL);
        s.clear = wr && mapped && (sel == SEL_CLEAR);
        return s;
    endfunction

endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] match_q,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nxt,
    output logic              clr_hold,
    output logic              match_wr
);
    localparam int unsigned HI_W = ADDR_W - SEL_MSB - 1;

    logic       mapped;
    reg_sel_e   sel;
    wr_strobe_t stb;
    logic       clr_q;

    generate
        if (HI_W > 0) begin : g_page_check
            assign mapped = (bus_addr[ADDR_W-1:SEL_MSB+1] == '0);
        end else begin : g_no_page_check
            assign mapped = 1'b1;
        end
    endgenerate

    assign sel      = reg_sel_e'(bus_addr[SEL_MSB:SEL_LSB]);
    assign stb      = decode_write(bus_wr, mapped, sel);
    assign match_wr = stb.match;

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (stb.ctrl) ctrl_nxt = ctrl_from_bits(bus_wdata[CTRL_BITS-1:0]);
    end

    // A write of 1 takes effect on its own edge; the held bit keeps it zero after.
    assign clr_hold = clr_q || (stb.clear && bus_wdata[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            ctrl_q  <= '0;
            clr_q   <= 1'b0;
        end else begin
            if (stb.match) match_q <= bus_wdata;
            ctrl_q <= ctrl_nxt;
            if (stb.clear) clr_q <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            unique case (sel)
                SEL_MATCH: bus_rdata = match_q;
                SEL_COUNT: bus_rdata = count;
                SEL_CTRL:  bus_rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_q};
                SEL_CLEAR: bus_rdata = {{(DATA_W-1){1'b0}}, clr_q};
                default:   bus_rdata = '0;
            endcase
        end
    end

    a_r2_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !mapped) |=> ($stable(match_q) && $stable(ctrl_q)))
        else $error("R2 unmapped write changed state");

    a_r3_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        stb.ctrl |=> (ctrl_q == $past(bus_wdata[CTRL_BITS-1:0])))
        else $error("R3 control write not captured");

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              wrap_en,
    input  logic              clr_hold,
    input  logic [DATA_W-1:0] match_val,
    output logic [DATA_W-1:0] count,
    output logic              hit
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] cnt_q, cnt_d;
    logic              step;

    assign hit   = (cnt_q == match_val);
    assign step  = run && tick;
    assign count = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_hold)     cnt_d = '0;
        else if (step)    cnt_d = (wrap_en && hit) ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_hold && !(run && tick)) |=> $stable(cnt_q))
        else $error("R4 count moved without a tick");

    a_r4_increment: assert property (@(posedge clk) disable iff (rst)
        (!clr_hold && run && tick && !(wrap_en && cnt_q == match_val))
        |=> (cnt_q == $past(cnt_q) + ONE))
        else $error("R4 count did not step by one");

    a_r6_clear_holds: assert property (@(posedge clk) disable iff (rst)
        clr_hold |=> (cnt_q == '0))
        else $error("R6 count not zero under clear");

    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr_hold && run && tick && wrap_en && cnt_q == match_val) |=> (cnt_q == '0))
        else $error("R7 wrap did not zero count");

endmodule

// File: rtl/cmt_irq.sv
module cmt_irq (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic run_nxt,
    input  logic match_wr,
    input  logic hit,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst)                       irq_q <= 1'b0;
        else if (!run_nxt || match_wr) irq_q <= 1'b0;
        else if (run && hit)           irq_q <= 1'b1;
    end

    assign irq = irq_q;

    a_r8_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(run && hit))
        else $error("R8 interrupt rose without a match");

    a_r9_drop: assert property (@(posedge clk) disable iff (rst)
        (!run_nxt || match_wr) |=> !irq_q)
        else $error("R9 interrupt not dropped");

    a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
        !run |=> !$rose(irq_q))
        else $error("R10 interrupt rose while stopped");

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] count, match_q;
    ctrl_t             ctrl_q, ctrl_nxt;
    logic              clr_hold, match_wr, hit;

    cmt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .count(count), .bus_rdata(bus_rdata),
        .match_q(match_q), .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt),
        .clr_hold(clr_hold), .match_wr(match_wr)
    );

    cmt_counter #(.DATA_W(DATA_W)) counter_i (
        .clk(clk), .rst(rst), .tick(tick),
        .run(ctrl_q.run), .wrap_en(ctrl_q.wrap_en), .clr_hold(clr_hold),
        .match_val(match_q), .count(count), .hit(hit)
    );

    cmt_irq irq_i (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .run_nxt(ctrl_nxt.run),
        .match_wr(match_wr), .hit(hit), .irq(irq)
    );

    a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!irq && count == '0))
        else $error("R1 reset state wrong");

endmodule

// File: tb/cmt_timer_tb_top.sv
module cmt_timer_tb_top;
    localparam logic [11:0] A_MATCH = 12'h000;
    localparam logic [11:0] A_COUNT = 12'h004;
    localparam logic [11:0] A_CTRL  = 12'h008;
    localparam logic [11:0] A_CLEAR = 12'h00C;
    localparam logic [11:0] A_OFF   = 12'h010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmt_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic arm(input logic [31:0] m, input logic [31:0] ctl);
        wr(A_CTRL, 32'd0);
        wr(A_CLEAR, 32'd1);
        wr(A_CLEAR, 32'd0);
        wr(A_MATCH, m);
        wr(A_CTRL, ctl);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cnt_before;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_MATCH, v); chk("R1 match", v, 0);
        rd(A_COUNT, v); chk("R1 count", v, 0);
        rd(A_CTRL,  v); chk("R1 ctrl",  v, 0);
        rd(A_CLEAR, v); chk("R1 clear", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2: match storage and unmapped offsets
        wr(A_MATCH, 32'hA5A5_5A5A); rd(A_MATCH, v); chk("R2 match pattern", v, 32'hA5A5_5A5A);
        wr(A_MATCH, 32'h7FFF_FFFF); rd(A_MATCH, v); chk("R2 match max", v, 32'h7FFF_FFFF);
        wr(A_MATCH | 12'h003, 32'h0000_000F); rd(A_MATCH, v); chk("R2 byte lanes ignored", v, 32'hF);
        wr(A_OFF, 32'h1234_5678); rd(A_OFF, v); chk("R2 unmapped read", v, 0);
        rd(A_MATCH, v); chk("R2 unmapped write", v, 32'hF);
        wr(A_OFF | A_CTRL, 32'h3); rd(A_CTRL, v); chk("R2 unmapped ctrl alias", v, 0);

        // R3: control bits
        wr(A_CTRL, 32'hFFFF_FFFE); rd(A_CTRL, v); chk("R3 ctrl upper zero", v, 32'h2);
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R3 ctrl both", v, 32'h3);
        wr(A_CTRL, 32'h0); rd(A_CTRL, v); chk("R3 ctrl off", v, 0);

        // R4: single ticks
        arm(32'h100, 32'h1);
        for (int k = 1; k <= 12; k++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
            rd(A_COUNT, v); chk("R4 tick step", v, k);
            @(negedge clk);
            rd(A_COUNT, v); chk("R4 no tick hold", v, k);
        end
        wr(A_CTRL, 32'h0);
        tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
        rd(A_COUNT, v); chk("R4 stopped hold", v, 12);

        // R5: count writes ignored
        wr(A_COUNT, 32'h1234); rd(A_COUNT, v); chk("R5 count write ignored", v, 12);

        // R6: level-held clear
        wr(A_CTRL, 32'h1);
        wr(A_CLEAR, 32'h1); rd(A_COUNT, v); chk("R6 clear zeroes", v, 0);
        rd(A_CLEAR, v); chk("R6 clear reads one", v, 1);
        tick = 1'b1; repeat (6) @(negedge clk); tick = 1'b0;
        rd(A_COUNT, v); chk("R6 held at zero", v, 0);
        wr(A_CLEAR, 32'h0); rd(A_COUNT, v); chk("R6 zero after release", v, 0);
        tick = 1'b1; repeat (3) @(negedge clk); tick = 1'b0;
        rd(A_COUNT, v); chk("R6 resumes", v, 3);

        // R7/R8: sweeps over match values, wrap and free-run
        for (int w = 0; w < 2; w++) begin
            for (int mi = 0; mi < 4; mi++) begin
                logic [31:0] m;
                m = (mi == 0) ? 32'hF : (mi == 1) ? 32'h10 : (mi == 2) ? 32'h13 : 32'h20;
                arm(m, (w == 1) ? 32'h3 : 32'h1);
                chk("R9 irq low after arm", {31'b0, irq}, 0);
                tick = 1'b1;
                for (int k = 1; k <= 2 * (int'(m) + 1) + 2; k++) begin
                    @(negedge clk);
                    rd(A_COUNT, v);
                    chk(w == 1 ? "R7 wrap count" : "R7 free count", v,
                        (w == 1) ? (k % (m + 1)) : k);
                    chk("R8 irq level", {31'b0, irq}, (k >= m + 1) ? 1 : 0);
                end
                tick = 1'b0;
            end
        end

        // R9: drop on match write (irq high from last sweep)
        chk("R9 irq high before", {31'b0, irq}, 1);
        rd(A_COUNT, cnt_before);
        wr(A_MATCH, 32'h7FFF_FFFF);
        chk("R9 drop on match write", {31'b0, irq}, 0);
        // R9: drop on run cleared
        arm(32'hF, 32'h1);
        tick = 1'b1; repeat (17) @(negedge clk); tick = 1'b0;
        chk("R8 irq before stop", {31'b0, irq}, 1);
        wr(A_CTRL, 32'h2);
        chk("R9 drop on run clear", {31'b0, irq}, 0);

        // R10: match while stopped
        wr(A_CLEAR, 32'h1); wr(A_CLEAR, 32'h0);
        wr(A_MATCH, 32'h0);
        repeat (8) @(negedge clk);
        chk("R10 no irq while stopped", {31'b0, irq}, 0);
        rd(A_COUNT, v); chk("R10 count at match", v, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule